// File: doc/BRIEF.md
# 6-and-2 Disk Data Field Decoder

This block sits behind a disk read channel once the sector's address field has been matched. A one-cycle `start` pulse arms it. From then on it takes one disk nibble on each cycle where `nib_valid` is high. It hunts for the three-nibble data prologue and maps every following nibble to a 6-bit code through an inverse translation ROM. It removes the running XOR chain that was applied when the field was written. From the recovered values it rebuilds the 256 sector bytes.

The first 86 recovered values are packed low-bit groups and are held in a small auxiliary store. The next 256 recovered values are the upper six bits of bytes 0 to 255. Each of these bytes is completed with its two low bits taken from the auxiliary store. The byte is then presented on a write strobe with its 8-bit address.

After the payload, the block checks a checksum nibble and a closing nibble. It then reports completion on a single `done` pulse. `err` is pulsed alongside `done` when any check failed.

Top module: `gcr62_data_decoder`

## Requirements
- R1: While reset is held, and on the first cycle after it, `byte_we`, `done` and `err` are low.
- R2: After `start`, the block hunts for the nibble sequence D5, AA, AD. A wrong nibble in the middle of that sequence restarts the hunt. The wrong nibble itself counts as a new first mark if it is D5.
- R3: The prologue must be complete by the 32nd valid nibble after `start`. If it is not, `done` and `err` pulse together on the cycle after that 32nd nibble, and no byte is written. A prologue that ends exactly on the 32nd nibble is accepted.
- R4: A valid disk nibble has bit 7 set. It has at least one pair of adjacent ones within bits 6..0, and at most one pair of adjacent zeros within bits 7..0. Code k maps to the k-th such nibble in ascending order, so 0x96 is code 0 and 0xFF is code 63. Any other nibble in the data, checksum or closing position makes `err` pulse with `done`, and it adds code 0 to the chain.
- R5: Each recovered value is the XOR of the nibble's code and the previous recovered value. The chain starts at zero at the end of the prologue.
- R6: The first 86 recovered values form the auxiliary entries 0..85. In entry i, bits 1:0 hold the low two bits of byte i, bits 3:2 those of byte i+86, and bits 5:4 those of byte i+172. Each pair is stored bit-swapped: bit 0 of the entry field is bit 1 of the byte.
- R7: Recovered value 86+j gives bits 7:2 of byte j. The byte is written with `byte_we` high and `byte_addr` = j on the cycle after its nibble. The 256 writes come in ascending address order.
- R8: The 343rd nibble after the prologue must bring the recovered value to zero; otherwise `err` pulses with `done`.
- R9: The 344th nibble after the prologue must be DE; otherwise `err` pulses with `done`.
- R10: `done` is a one-cycle pulse on the cycle after the closing nibble, and it is never high with `byte_we`. `err` is high only together with `done`. `start` has no effect until the block is idle again.
- R11: Cycles with `nib_valid` low have no effect, whatever value `nib` carries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Arms the prologue hunt when idle |
| nib_valid | input | 1 | `nib` carries a disk nibble this cycle |
| nib | input | 8 | Disk nibble |
| byte_we | output | 1 | Byte write strobe |
| byte_addr | output | 8 | Byte index within the sector |
| byte_data | output | 8 | Rebuilt sector byte |
| done | output | 1 | End-of-field pulse |
| err | output | 1 | Error flag, valid with `done` |

## Verification
The decoder is driven with whole fields built by an encoder in the bench from known sectors. One sector is an address ramp, whose low bits cycle through every pair value in each group. Another is a scrambled pattern, whose upper bits exercise the full code range, so that a wrong slot or a missing bit swap shows up as a mismatch when the result is read back.

Prologue patterns with repeated first marks, a false second mark and garbage leads separate correct resynchronisation from a hunt that simply restarts. Runs of exactly 32 nibbles and of 32 non-matching nibbles mark the timeout boundary. Fields with a corrupted checksum, a wrong closing nibble or an illegal nibble, and streams with idle gaps carrying mark values, show that each error is raised and that idle cycles change nothing.

// File: rtl/gcr62_pkg.sv
package gcr62_pkg;
  localparam int AUX_N   = 86;
  localparam int BYTE_N  = 256;
  localparam int DATA_N  = AUX_N + BYTE_N;
  localparam int CODE_W  = 6;
  localparam int AUX_AW  = $clog2(AUX_N);

  localparam logic [7:0] MARK_A   = 8'hD5;
  localparam logic [7:0] MARK_B   = 8'hAA;
  localparam logic [7:0] MARK_C   = 8'hAD;
  localparam logic [7:0] CLOSE_NB = 8'hDE;

  typedef enum logic [2:0] {PH_IDLE, PH_HUNT, PH_DATA, PH_CSUM, PH_CLOSE} phase_t;

  typedef logic [255:0][CODE_W:0] rom_t;

  // legal disk nibble: top bit set, some adjacent ones below it, at most one adjacent-zero pair
  function automatic logic nib_legal(input logic [7:0] n);
    int ones_pairs;
    int zero_pairs;
    ones_pairs = 0;
    zero_pairs = 0;
    for (int i = 0; i < 6; i++)
      if (n[i] && n[i+1]) ones_pairs++;
    for (int i = 0; i < 7; i++)
      if (!n[i] && !n[i+1]) zero_pairs++;
    return n[7] && (ones_pairs > 0) && (zero_pairs <= 1);
  endfunction

  function automatic rom_t build_rom();
    rom_t r;
    int k;
    k = 0;
    for (int n = 0; n < 256; n++) begin
      if (nib_legal(8'(n))) begin
        r[n] = {1'b1, CODE_W'(k)};
        k++;
      end else begin
        r[n] = '0;
      end
    end
    return r;
  endfunction

  // which third of the sector a byte index falls in
  function automatic logic [1:0] grp_of(input int j);
    if (j < AUX_N)          return 2'd0;
    else if (j < 2 * AUX_N) return 2'd1;
    else                    return 2'd2;
  endfunction

  function automatic logic [AUX_AW-1:0] slot_of(input int j);
    return AUX_AW'(j - AUX_N * int'(grp_of(j)));
  endfunction

  // pull a bit-swapped low pair out of an auxiliary entry
  function automatic logic [1:0] low_pair(input logic [CODE_W-1:0] a, input logic [1:0] g);
    logic [1:0] f;
    f = a[2*g +: 2];
    return {f[0], f[1]};
  endfunction
endpackage

// File: rtl/gcr62_rom.sv
module gcr62_rom
  import gcr62_pkg::*;
(
  input  logic [7:0]        nib,
  output logic [CODE_W-1:0] code,
  output logic              legal
);
  localparam rom_t TABLE = build_rom();

  assign {legal, code} = TABLE[nib];
endmodule

// File: rtl/gcr62_sync.sv
module gcr62_sync
  import gcr62_pkg::*;
#(
  parameter int LIMIT = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       step,
  input  logic [7:0] nib,
  output logic       found,
  output logic       timeout
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [1:0]    stage;
  logic [CW-1:0] cnt;

  assign found   = step && (stage == 2'd2) && (nib == MARK_C);
  assign timeout = step && !found && (cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      stage <= 2'd0;
      cnt   <= '0;
    end else if (step && !found && !timeout) begin
      cnt <= cnt + 1'b1;
      if (nib == MARK_A)                        stage <= 2'd1;
      else if (stage == 2'd1 && nib == MARK_B)  stage <= 2'd2;
      else                                      stage <= 2'd0;
    end
  end

  assert_hunt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CW'(LIMIT));
  assert_found_after_mark_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && stage == 2'd0) |=> !found);
endmodule

// File: rtl/gcr62_aux.sv
module gcr62_aux
  import gcr62_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [AUX_AW-1:0] waddr,
  input  logic [CODE_W-1:0] wdata,
  input  logic [AUX_AW-1:0] raddr,
  output logic [CODE_W-1:0] rdata
);
  logic [CODE_W-1:0] mem [AUX_N];

  always_ff @(posedge clk)
    if (we && int'(waddr) < AUX_N) mem[waddr] <= wdata;

  assign rdata = (int'(raddr) < AUX_N) ? mem[raddr] : '0;

  assert_aux_index_R6: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> int'(waddr) < AUX_N);
endmodule

// File: rtl/gcr62_data_decoder.sv
module gcr62_data_decoder
  import gcr62_pkg::*;
#(
  parameter int SYNC_LIMIT = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       nib_valid,
  input  logic [7:0] nib,
  output logic       byte_we,
  output logic [7:0] byte_addr,
  output logic [7:0] byte_data,
  output logic       done,
  output logic       err
);
  localparam int IW = $clog2(DATA_N + 1);

  phase_t            phase;
  logic [IW-1:0]     idx;
  logic [CODE_W-1:0] run;
  logic              bad;

  logic              hunt_step, data_step, arm;
  logic              sync_found, sync_timeout;
  logic [CODE_W-1:0] code;
  logic              legal;
  logic [CODE_W-1:0] chain;
  logic              aux_we;
  int                byte_j;
  logic [1:0]        grp;
  logic [CODE_W-1:0] aux_rd;
  logic [1:0]        field;

  assign arm       = (phase == PH_IDLE) && start;
  assign hunt_step = (phase == PH_HUNT) && nib_valid;
  assign data_step = (phase == PH_DATA) && nib_valid;
  assign chain     = run ^ (legal ? code : '0);
  assign aux_we    = data_step && (int'(idx) < AUX_N);
  assign byte_j    = int'(idx) - AUX_N;
  assign grp       = grp_of(byte_j);
  assign field     = low_pair(aux_rd, grp);

  gcr62_sync #(.LIMIT(SYNC_LIMIT)) u_sync (
    .clk(clk), .rst_n(rst_n), .clear(arm), .step(hunt_step), .nib(nib),
    .found(sync_found), .timeout(sync_timeout)
  );

  gcr62_rom u_rom (.nib(nib), .code(code), .legal(legal));

  gcr62_aux u_aux (
    .clk(clk), .rst_n(rst_n), .we(aux_we), .waddr(AUX_AW'(idx)), .wdata(chain),
    .raddr(slot_of(byte_j)), .rdata(aux_rd)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      idx       <= '0;
      run       <= '0;
      bad       <= 1'b0;
      byte_we   <= 1'b0;
      byte_addr <= '0;
      byte_data <= '0;
      done      <= 1'b0;
      err       <= 1'b0;
    end else begin
      byte_we <= 1'b0;
      done    <= 1'b0;
      err     <= 1'b0;
      unique case (phase)
        PH_IDLE: if (start) phase <= PH_HUNT;
        PH_HUNT: begin
          if (sync_found) begin
            phase <= PH_DATA;
            idx   <= '0;
            run   <= '0;
            bad   <= 1'b0;
          end else if (sync_timeout) begin
            done  <= 1'b1;
            err   <= 1'b1;
            phase <= PH_IDLE;
          end
        end
        PH_DATA: if (nib_valid) begin
          run <= chain;
          idx <= idx + 1'b1;
          if (!legal) bad <= 1'b1;
          if (int'(idx) >= AUX_N) begin
            byte_we   <= 1'b1;
            byte_addr <= 8'(byte_j);
            byte_data <= {chain, field};
          end
          if (int'(idx) == DATA_N - 1) phase <= PH_CSUM;
        end
        PH_CSUM: if (nib_valid) begin
          if (!legal || chain != '0) bad <= 1'b1;
          phase <= PH_CLOSE;
        end
        PH_CLOSE: if (nib_valid) begin
          done  <= 1'b1;
          err   <= bad || !legal || (nib != CLOSE_NB);
          phase <= PH_IDLE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assert_addr_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_we && $past(byte_we)) |-> byte_addr == $past(byte_addr) + 8'd1);
  assert_err_with_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);
  assert_done_alone_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !byte_we);
  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DATA && !nib_valid) |=> !byte_we && !done);
endmodule

// File: tb/tb_gcr62_data_decoder.sv
`timescale 1ns/1ps
module tb_gcr62_data_decoder;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       nib_valid = 1'b0;
  logic [7:0] nib = 8'h00;
  logic       byte_we, done, err;
  logic [7:0] byte_addr, byte_data;

  always #2.5 clk = ~clk;

  gcr62_data_decoder dut (
    .clk(clk), .rst_n(rst_n), .start(start), .nib_valid(nib_valid), .nib(nib),
    .byte_we(byte_we), .byte_addr(byte_addr), .byte_data(byte_data),
    .done(done), .err(err)
  );

  localparam logic [7:0] TBL [64] = '{
    8'h96,8'h97,8'h9A,8'h9B,8'h9D,8'h9E,8'h9F,8'hA6,8'hA7,8'hAB,8'hAC,8'hAD,8'hAE,8'hAF,8'hB2,8'hB3,
    8'hB4,8'hB5,8'hB6,8'hB7,8'hB9,8'hBA,8'hBB,8'hBC,8'hBD,8'hBE,8'hBF,8'hCB,8'hCD,8'hCE,8'hCF,8'hD3,
    8'hD6,8'hD7,8'hD9,8'hDA,8'hDB,8'hDC,8'hDD,8'hDE,8'hDF,8'hE5,8'hE6,8'hE7,8'hE9,8'hEA,8'hEB,8'hEC,
    8'hED,8'hEE,8'hEF,8'hF2,8'hF3,8'hF4,8'hF5,8'hF6,8'hF7,8'hF9,8'hFA,8'hFB,8'hFC,8'hFD,8'hFE,8'hFF};

  int checks = 0;
  int fails  = 0;
  string cur_req = "R10";

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // reference model state, updated on each rising edge
  int  m_mode = 0, m_stage = 0, m_cnt = 0, m_prev = 0;
  bit  m_bad = 0;
  int  m_vals[$];
  bit  e_we = 0, e_done = 0, e_err = 0;
  int  e_addr = 0, e_data = 0;
  bit  model_on = 0;

  function automatic int lookup(input logic [7:0] n, output bit ok);
    for (int k = 0; k < 64; k++) if (TBL[k] == n) begin ok = 1; return k; end
    ok = 0;
    return 0;
  endfunction

  always @(posedge clk) begin
    bit ok;
    int c, t, k, j, f;
    e_we = 0; e_done = 0; e_err = 0;
    if (!rst_n) begin
      m_mode = 0;
    end else begin
      case (m_mode)
        0: if (start) begin m_mode = 1; m_stage = 0; m_cnt = 0; end
        1: if (nib_valid) begin
          m_cnt++;
          if (m_stage == 2 && nib == 8'hAD) begin
            m_mode = 2; m_vals.delete(); m_prev = 0; m_bad = 0;
          end else begin
            if (nib == 8'hD5) m_stage = 1;
            else if (m_stage == 1 && nib == 8'hAA) m_stage = 2;
            else m_stage = 0;
            if (m_cnt == 32) begin e_done = 1; e_err = 1; m_mode = 0; end
          end
        end
        2: if (nib_valid) begin
          c = lookup(nib, ok);
          if (!ok) m_bad = 1;
          t = m_prev ^ c; m_prev = t;
          k = m_vals.size();
          m_vals.push_back(t);
          if (k >= 86) begin
            j = k - 86;
            f = (m_vals[j % 86] >> (2 * (j / 86))) & 3;
            e_we = 1; e_addr = j;
            e_data = (t << 2) | ((f & 1) << 1) | (f >> 1);
          end
          if (k == 341) m_mode = 3;
        end
        3: if (nib_valid) begin
          c = lookup(nib, ok);
          if (!ok || (m_prev ^ c) != 0) m_bad = 1;
          m_mode = 4;
        end
        default: if (nib_valid) begin
          e_done = 1;
          e_err = m_bad || nib != 8'hDE;
          m_mode = 0;
        end
      endcase
    end
  end

  // per-cycle comparison and capture, away from the active edge
  int n_we = 0, n_done = 0;
  bit last_err = 0;
  logic [7:0] cap [256];

  always @(negedge clk) begin
    if (model_on) begin
      chk(byte_we == e_we, "R7", "byte_we", byte_we, e_we);
      if (e_we) begin
        chk(byte_addr == 8'(e_addr), "R7", "byte_addr", byte_addr, e_addr);
        chk(byte_data == 8'(e_data), "R5 R6", "byte_data", byte_data, e_data);
      end
      chk(done == e_done, "R10", "done", done, e_done);
      chk(err == e_err, cur_req, "err", err, e_err);
      if (byte_we) begin n_we++; cap[byte_addr] = byte_data; end
      if (done) begin n_done++; last_err = err; end
    end
  end

  logic [7:0] src [256];
  logic [7:0] tx[$];

  function automatic int swp(input int x);
    return ((x & 1) << 1) | ((x >> 1) & 1);
  endfunction

  task automatic make_payload();
    int a [86];
    int prev, v;
    for (int i = 0; i < 86; i++) begin
      a[i] = swp(src[i] & 3) | (swp(src[i+86] & 3) << 2);
      if (i + 172 < 256) a[i] = a[i] | (swp(src[i+172] & 3) << 4);
    end
    prev = 0;
    for (int k = 0; k < 342; k++) begin
      v = (k < 86) ? a[k] : int'(src[k-86]) >> 2;
      tx.push_back(TBL[v ^ prev]);
      prev = v;
    end
    tx.push_back(TBL[prev]);
    tx.push_back(8'hDE);
    tx.push_back(8'hAA);
    tx.push_back(8'hEB);
  endtask

  task automatic cyc(input bit v, input logic [7:0] n, input bit s);
    @(negedge clk);
    nib_valid = v; nib = n; start = s;
  endtask

  // gap: idle cycle after every 7th nibble; poke: start pulse at nibble 150
  task automatic send(input bit gap, input bit poke);
    n_we = 0; n_done = 0; last_err = 0;
    cyc(0, 8'h00, 1);
    for (int i = 0; i < tx.size(); i++) begin
      cyc(1, tx[i], poke && i == 150);
      if (gap && (i % 7) == 6) cyc(0, 8'hD5, 0);
    end
    for (int i = 0; i < 4; i++) cyc(0, 8'hAD, 0);
  endtask

  function automatic bit same_bytes();
    for (int i = 0; i < 256; i++) if (cap[i] !== src[i]) return 0;
    return 1;
  endfunction

  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=0", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) cyc(0, 8'h00, 0);
    chk(byte_we == 0, "R1", "byte_we in reset", byte_we, 0);
    chk(done == 0 && err == 0, "R1", "done/err in reset", {done, err}, 0);
    cyc(0, 8'h00, 0);
    rst_n = 1;
    @(negedge clk);
    chk(byte_we == 0 && done == 0 && err == 0, "R1", "outputs after reset", {byte_we, done, err}, 0);
    model_on = 1;

    // ramp sector, garbage lead before the prologue
    cur_req = "R2";
    for (int i = 0; i < 256; i++) src[i] = 8'(i);
    tx = '{8'hFF, 8'h96, 8'hD5, 8'hAA, 8'hAD};
    make_payload();
    send(0, 0);
    chk(n_we == 256, "R7", "write count", n_we, 256);
    chk(same_bytes(), "R6 R7", "ramp round trip", 0, 1);
    chk(n_done == 1 && last_err == 0, "R2", "clean done", last_err, 0);

    // scrambled sector, resync prologue, idle gaps, start while busy
    cur_req = "R11";
    for (int i = 0; i < 256; i++) src[i] = 8'((i * 173 + 91) ^ (i >> 2));
    tx = '{8'hD5, 8'hD5, 8'hAA, 8'hD5, 8'hAA, 8'hD5, 8'hAA, 8'hAD};
    make_payload();
    send(1, 1);
    chk(same_bytes(), "R11", "gapped round trip", 0, 1);
    chk(n_done == 1 && last_err == 0, "R10", "start ignored while busy", n_done, 1);
    chk(cap[200] == src[200], "R6", "third-group byte", cap[200], src[200]);

    // bad checksum nibble
    cur_req = "R8";
    tx = '{8'hD5, 8'hAA, 8'hAD};
    make_payload();
    tx[3 + 342] = (tx[3 + 342] == 8'h96) ? 8'h97 : 8'h96;
    send(0, 0);
    chk(n_done == 1 && last_err == 1, "R8", "checksum error", last_err, 1);

    // bad closing nibble
    cur_req = "R9";
    tx = '{8'hD5, 8'hAA, 8'hAD};
    make_payload();
    tx[3 + 343] = 8'hDF;
    send(0, 0);
    chk(last_err == 1, "R9", "closing error", last_err, 1);
    chk(same_bytes(), "R9", "bytes still intact", 0, 1);

    // illegal nibble inside the payload
    cur_req = "R4";
    tx = '{8'hD5, 8'hAA, 8'hAD};
    make_payload();
    tx[3 + 100] = 8'h00;
    send(0, 0);
    chk(n_we == 256 && last_err == 1, "R4", "illegal nibble", last_err, 1);

    // timeout after 32 non-matching nibbles
    cur_req = "R3";
    tx.delete();
    for (int i = 0; i < 32; i++) tx.push_back(8'hFF);
    send(0, 0);
    chk(n_done == 1 && last_err == 1 && n_we == 0, "R3", "timeout", {n_done, last_err}, 3);

    // prologue ending exactly on the 32nd nibble
    tx.delete();
    for (int i = 0; i < 29; i++) tx.push_back(8'hFF);
    tx.push_back(8'hD5); tx.push_back(8'hAA); tx.push_back(8'hAD);
    make_payload();
    send(0, 0);
    chk(last_err == 0 && same_bytes(), "R3", "boundary accept", last_err, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule